// File: doc/BRIEF.md
# Guarded Configuration Register with Enable-Latch Sequencing

This block holds one configuration byte that sits at a reserved address above the data array of a serial memory. A serial front end decodes bus traffic and hands the block single-cycle strobes: an address phase of a write (with the word address), a data byte, a stop condition and a read request. The block answers with a registered acknowledge one cycle later. On a read it also returns the register byte. Its configuration fields drive neighbouring logic: a watchdog period select, a block-protect range, a protect-enable flag and a power-up flag.

The persistent fields change only through a three-step procedure. First a write of 02h sets the write-enable latch. Next a write of 06h sets the register-write latch. Finally a write with the register-write latch bit cleared carries the new persistent value. That value is stored when the stop that follows arrives, and a busy window models the storage cycle. During that window every transaction is refused. The block also reports two address-counter side effects to the array logic: a "counter to zero" pulse after a register read, and a "counter undefined" pulse after a register write.

States: IDLE (no register transaction open), SEL (register address accepted), HELD (one data byte captured, waiting for stop), COMMIT (storage cycle running). Transitions:
- IDLE/SEL/HELD to SEL on a write address equal to the register address.
- IDLE/SEL/HELD to IDLE on any other write address.
- SEL to HELD on a data byte.
- SEL to IDLE on a read, or on a stop.
- HELD to IDLE on a stop that is not a storage request.
- HELD to COMMIT on a stop that is a storage request.
- COMMIT to IDLE when the busy timer expires.

When strobes coincide, the priority is write address, then read, then data, then stop.

Top module: `cr_guard`

## Requirements
- R1: After reset all register bits are 0, the acknowledge and both address pulses are low, busy is low, and the state is IDLE.
- R2: A write address equal to FFFFh is acknowledged in the next cycle. Any other write address is not acknowledged, and the data bytes and stops that follow it leave the register unchanged.
- R3: In SEL the first data byte is acknowledged. Further data bytes before the stop are not acknowledged and have no effect on the stored value.
- R4: A stop in HELD that is not a storage request performs a volatile write. The write-enable latch (bit 1) takes byte bit 1. The register-write latch (bit 2) is set only when byte bits 2 and 1 are both 1 and the write-enable latch was already set; otherwise it is cleared.
- R5: A stop in HELD is a storage request when both latches are set and byte bit 2 is 0. At that stop the persistent fields take the byte: bit 7 protect-enable, bits 6:5 watchdog select, bits 4:3 block protect, bit 0 power-up. Busy is then high for exactly COMMIT_CYCLES cycles, and the register-write latch is 0 when busy falls. The write-enable latch is kept.
- R6: A byte that changes persistent bits while either latch is clear leaves the persistent fields unchanged.
- R7: While busy is high, no strobe is acknowledged and no register bit changes.
- R8: A read in SEL is acknowledged in the next cycle. In the same cycle it returns the byte {protect-enable, watchdog select[1:0], block protect[1:0], register-write latch, write-enable latch, power-up} and pulses the counter-to-zero output. A second read without a new address is not acknowledged.
- R9: The cycle after a stop that ends a register write carrying a data byte, the counter-undefined output pulses for one cycle.
- R10: A stop in SEL with no data byte changes no register bit and gives no counter-undefined pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_addr_vld | input | 1 | Address phase of a write, one-cycle strobe |
| wr_addr | input | ADDR_W | Word address of that write |
| data_vld | input | 1 | Data byte strobe |
| data_in | input | 8 | Data byte from the master |
| stop_vld | input | 1 | Stop condition strobe |
| rd_req | input | 1 | Read request at the current address |
| ack_o | output | 1 | Acknowledge for the strobe of the previous cycle |
| rd_data_o | output | 8 | Register byte, updated on an acknowledged read |
| busy_o | output | 1 | Storage cycle running |
| addr_zero_o | output | 1 | Address counter to be cleared |
| addr_undef_o | output | 1 | Address counter contents undefined |
| wpen_o | output | 1 | Protect-enable field |
| wdsel_o | output | 2 | Watchdog select field |
| bprot_o | output | 2 | Block-protect field |
| pup_o | output | 1 | Power-up field |

## Verification
The acknowledge, the read byte and both address pulses are registered, so each is due in the cycle after the edge that samples its strobe. The field outputs and busy change on that same edge. The bench drives a strobe for one edge and reads the results just after that edge. A behavioural model advances on the same edges and is compared with every output at each falling edge. The busy window is checked by counting cycles from the stop edge until busy falls, COMMIT_CYCLES cycles later.

// File: rtl/cr_guard_pkg.sv
package cr_guard_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEL    = 2'd1,
        ST_HELD   = 2'd2,
        ST_COMMIT = 2'd3
    } cr_state_e;

    // Bit positions of the register byte (decoded by software and neighbours)
    localparam int B_WPEN = 7;
    localparam int B_WD_H = 6;
    localparam int B_WD_L = 5;
    localparam int B_BP_H = 4;
    localparam int B_BP_L = 3;
    localparam int B_RWL  = 2;
    localparam int B_WEL  = 1;
    localparam int B_PUP  = 0;
endpackage

// File: rtl/cr_guard_timer.sv
module cr_guard_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/cr_guard_regs.sv
module cr_guard_regs
    import cr_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vol_we,
    input  logic       nv_we,
    input  logic       clr_rwl,
    input  logic [7:0] wr_byte,
    output logic [7:0] cr_byte
);
    logic       wpen, wel, rwl, pup;
    logic [1:0] wd, bp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wpen <= 1'b0;
            wd   <= 2'b00;
            bp   <= 2'b00;
            pup  <= 1'b0;
            wel  <= 1'b0;
            rwl  <= 1'b0;
        end else begin
            if (nv_we) begin
                wpen <= wr_byte[B_WPEN];
                wd   <= wr_byte[B_WD_H:B_WD_L];
                bp   <= wr_byte[B_BP_H:B_BP_L];
                pup  <= wr_byte[B_PUP];
            end else if (vol_we) begin
                wel  <= wr_byte[B_WEL];
                rwl  <= wr_byte[B_RWL] & wr_byte[B_WEL] & wel;
            end
            if (clr_rwl) begin
                rwl  <= 1'b0;
            end
        end
    end

    assign cr_byte = {wpen, wd, bp, rwl, wel, pup};
endmodule

// File: rtl/cr_guard_fsm.sv
module cr_guard_fsm
    import cr_guard_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              data_vld,
    input  logic [7:0]        data_in,
    input  logic              stop_vld,
    input  logic              rd_req,
    input  logic [7:0]        cr_byte,
    input  logic              tmr_done,
    output logic              vol_we,
    output logic              nv_we,
    output logic [7:0]        hold_byte,
    output logic              ack_o,
    output logic [7:0]        rd_data_o,
    output logic              addr_zero_o,
    output logic              addr_undef_o
);
    cr_state_e state, state_nx;
    logic      hit, permit, take_byte, do_ack, do_read, do_undef;

    assign hit    = (wr_addr == REG_ADDR);
    assign permit = cr_byte[B_WEL] & cr_byte[B_RWL] & ~hold_byte[B_RWL];

    always_comb begin
        state_nx  = state;
        take_byte = 1'b0;
        do_ack    = 1'b0;
        do_read   = 1'b0;
        do_undef  = 1'b0;
        vol_we    = 1'b0;
        nv_we     = 1'b0;
        unique case (state)
            ST_COMMIT: begin
                if (tmr_done) state_nx = ST_IDLE;
            end
            ST_IDLE, ST_SEL, ST_HELD: begin
                if (wr_addr_vld) begin
                    state_nx = hit ? ST_SEL : ST_IDLE;
                    do_ack   = hit;
                end else if (rd_req) begin
                    if (state == ST_SEL) begin
                        do_ack   = 1'b1;
                        do_read  = 1'b1;
                        state_nx = ST_IDLE;
                    end
                end else if (data_vld) begin
                    if (state == ST_SEL) begin
                        do_ack    = 1'b1;
                        take_byte = 1'b1;
                        state_nx  = ST_HELD;
                    end
                end else if (stop_vld) begin
                    if (state == ST_HELD) begin
                        do_undef = 1'b1;
                        nv_we    = permit;
                        vol_we   = ~permit;
                        state_nx = permit ? ST_COMMIT : ST_IDLE;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and captured byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hold_byte <= 8'h00;
        end else begin
            state <= state_nx;
            if (take_byte) hold_byte <= data_in;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o        <= 1'b0;
            rd_data_o    <= 8'h00;
            addr_zero_o  <= 1'b0;
            addr_undef_o <= 1'b0;
        end else begin
            ack_o        <= do_ack;
            addr_zero_o  <= do_read;
            addr_undef_o <= do_undef;
            if (do_read) rd_data_o <= cr_byte;
        end
    end
endmodule

// File: rtl/cr_guard.sv
module cr_guard
    import cr_guard_pkg::*;
#(
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR      = '1,
    parameter int                COMMIT_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              data_vld,
    input  logic [7:0]        data_in,
    input  logic              stop_vld,
    input  logic              rd_req,
    output logic              ack_o,
    output logic [7:0]        rd_data_o,
    output logic              busy_o,
    output logic              addr_zero_o,
    output logic              addr_undef_o,
    output logic              wpen_o,
    output logic [1:0]        wdsel_o,
    output logic [1:0]        bprot_o,
    output logic              pup_o
);
    logic       vol_we, nv_we, tmr_done;
    logic [7:0] hold_byte, cr_byte;

    cr_guard_fsm #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_addr_vld(wr_addr_vld), .wr_addr(wr_addr),
        .data_vld(data_vld), .data_in(data_in),
        .stop_vld(stop_vld), .rd_req(rd_req),
        .cr_byte(cr_byte), .tmr_done(tmr_done),
        .vol_we(vol_we), .nv_we(nv_we), .hold_byte(hold_byte),
        .ack_o(ack_o), .rd_data_o(rd_data_o),
        .addr_zero_o(addr_zero_o), .addr_undef_o(addr_undef_o)
    );

    cr_guard_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .vol_we(vol_we), .nv_we(nv_we), .clr_rwl(tmr_done),
        .wr_byte(hold_byte), .cr_byte(cr_byte)
    );

    cr_guard_timer #(.CYCLES(COMMIT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start(nv_we), .busy(busy_o), .done(tmr_done)
    );

    assign wpen_o  = cr_byte[B_WPEN];
    assign wdsel_o = cr_byte[B_WD_H:B_WD_L];
    assign bprot_o = cr_byte[B_BP_H:B_BP_L];
    assign pup_o   = cr_byte[B_PUP];
endmodule

// File: rtl/cr_guard_chk.sv
module cr_guard_chk #(
    parameter int CYCLES = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_addr_vld,
    input logic       data_vld,
    input logic       rd_req,
    input logic       ack_o,
    input logic       busy_o,
    input logic       addr_zero_o,
    input logic       addr_undef_o,
    input logic [7:0] cr_byte
);
    int blen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blen <= 0;
        else        blen <= busy_o ? blen + 1 : 0;
    end

    p_ack_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(wr_addr_vld | data_vld | rd_req));

    p_rwl_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cr_byte[2] |-> cr_byte[1]);

    p_nv_with_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cr_byte[7:3], cr_byte[0]}) |-> $rose(busy_o));

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (blen == CYCLES));

    p_rwl_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !cr_byte[2]);

    p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !ack_o);

    p_zero_acked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_zero_o |-> ack_o);

    p_undef_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_undef_o |-> !ack_o);
endmodule

bind cr_guard cr_guard_chk #(.CYCLES(COMMIT_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_addr_vld(wr_addr_vld), .data_vld(data_vld), .rd_req(rd_req),
    .ack_o(ack_o), .busy_o(busy_o),
    .addr_zero_o(addr_zero_o), .addr_undef_o(addr_undef_o),
    .cr_byte(cr_byte)
);

// File: tb/cr_guard_bench.sv
module cr_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_addr_vld = 1'b0, data_vld = 1'b0, stop_vld = 1'b0, rd_req = 1'b0;
    logic [15:0] wr_addr = 16'h0;
    logic [7:0]  data_in = 8'h0;
    logic        ack_o, busy_o, addr_zero_o, addr_undef_o, wpen_o, pup_o;
    logic [7:0]  rd_data_o;
    logic [1:0]  wdsel_o, bprot_o;

    cr_guard #(.ADDR_W(16), .COMMIT_CYCLES(CYC)) u_cr_guard (
        .clk(clk), .rst_n(rst_n),
        .wr_addr_vld(wr_addr_vld), .wr_addr(wr_addr),
        .data_vld(data_vld), .data_in(data_in),
        .stop_vld(stop_vld), .rd_req(rd_req),
        .ack_o(ack_o), .rd_data_o(rd_data_o), .busy_o(busy_o),
        .addr_zero_o(addr_zero_o), .addr_undef_o(addr_undef_o),
        .wpen_o(wpen_o), .wdsel_o(wdsel_o), .bprot_o(bprot_o), .pup_o(pup_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // Behavioural reference model
    int        m_st;          // 0 idle, 1 register selected, 2 byte held
    int        m_cnt;
    bit [7:0]  m_hold, m_rd;
    bit        m_wel, m_rwl, m_ack, m_zero, m_undef;
    bit [5:0]  m_nv;          // {wpen, wd[1:0], bp[1:0], pup}

    function automatic bit [7:0] m_cr();
        return {m_nv[5:1], m_rwl, m_wel, m_nv[0]};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_hold = 0; m_rd = 0;
            m_wel = 0; m_rwl = 0; m_ack = 0; m_zero = 0; m_undef = 0; m_nv = 0;
        end else begin
            m_ack = 0; m_zero = 0; m_undef = 0;
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) m_rwl = 0;
            end else if (wr_addr_vld) begin
                m_ack = (wr_addr == 16'hFFFF);
                m_st  = m_ack ? 1 : 0;
            end else if (rd_req) begin
                if (m_st == 1) begin
                    m_ack = 1; m_zero = 1; m_rd = m_cr(); m_st = 0;
                end
            end else if (data_vld) begin
                if (m_st == 1) begin
                    m_ack = 1; m_hold = data_in; m_st = 2;
                end
            end else if (stop_vld) begin
                if (m_st == 2) begin
                    m_undef = 1;
                    if (m_wel && m_rwl && !m_hold[2]) begin
                        m_nv  = {m_hold[7:3], m_hold[0]};
                        m_cnt = CYC;
                    end else begin
                        m_rwl = m_hold[2] & m_hold[1] & m_wel;
                        m_wel = m_hold[1];
                    end
                end
                m_st = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_cmp++;
            if ({ack_o, rd_data_o, busy_o, addr_zero_o, addr_undef_o,
                 wpen_o, wdsel_o, bprot_o, pup_o} !==
                {m_ack, m_rd, (m_cnt > 0), m_zero, m_undef, m_nv}) begin
                n_bad++;
                $display("FAIL %s model compare: got ack=%b rd=%h busy=%b z=%b u=%b f=%b%b%b%b exp ack=%b rd=%h busy=%b z=%b u=%b f=%b",
                    cur_req, ack_o, rd_data_o, busy_o, addr_zero_o, addr_undef_o,
                    wpen_o, wdsel_o, bprot_o, pup_o,
                    m_ack, m_rd, (m_cnt > 0), m_zero, m_undef, m_nv);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Each strobe lasts one edge; results are read just after that edge
    task automatic do_addr(input logic [15:0] a);
        wr_addr_vld = 1; wr_addr = a; tick(); wr_addr_vld = 0;
    endtask
    task automatic do_data(input logic [7:0] d);
        data_vld = 1; data_in = d; tick(); data_vld = 0;
    endtask
    task automatic do_stop();
        stop_vld = 1; tick(); stop_vld = 0;
    endtask
    task automatic do_rd();
        rd_req = 1; tick(); rd_req = 0;
    endtask

    task automatic read_cr(input string req, input int exp);
        do_addr(16'hFFFF);
        do_rd();
        chk(req, ack_o, 1);
        chk(req, rd_data_o, exp);
        chk(req, addr_zero_o, 1);
        tick();
    endtask

    task automatic write_cr(input logic [7:0] d);
        do_addr(16'hFFFF);
        do_data(d);
        do_stop();
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        chk("R1", {ack_o, busy_o, addr_zero_o, addr_undef_o}, 0);
        chk("R1", {wpen_o, wdsel_o, bprot_o, pup_o}, 0);
        rst_n = 1;
        tick();

        cur_req = "R2";
        do_addr(16'h1234);
        chk("R2 foreign address", ack_o, 0);
        do_data(8'h02);
        chk("R2 data after foreign address", ack_o, 0);
        do_stop();
        tick();
        read_cr("R2 no change", 8'h00);

        cur_req = "R3";
        do_addr(16'hFFFF);
        chk("R2 register address", ack_o, 1);
        do_data(8'h02);
        chk("R3 first byte", ack_o, 1);
        do_data(8'hFF);
        chk("R3 second byte", ack_o, 0);
        cur_req = "R9";
        do_stop();
        chk("R9 undefined pulse", addr_undef_o, 1);
        tick();
        chk("R9 pulse one cycle", addr_undef_o, 0);

        cur_req = "R8";
        do_addr(16'hFFFF);
        do_rd();
        chk("R8 read ack", ack_o, 1);
        chk("R3 R4 first step", rd_data_o, 8'h02);
        chk("R8 zero pulse", addr_zero_o, 1);
        do_rd();
        chk("R8 second read", ack_o, 0);
        tick();

        cur_req = "R4";
        write_cr(8'h06);
        read_cr("R4 second step", 8'h06);

        cur_req = "R5";
        do_addr(16'hFFFF);
        do_data(8'hF9);
        do_stop();
        chk("R5 busy", busy_o, 1);
        chk("R5 fields", {wpen_o, wdsel_o, bprot_o, pup_o}, 6'h3F);
        cur_req = "R7";
        do_addr(16'hFFFF);
        chk("R7 nack while busy", ack_o, 0);
        do_data(8'h00);
        chk("R7 data while busy", ack_o, 0);
        do_stop();
        repeat (CYC) tick();
        chk("R5 busy done", busy_o, 0);
        read_cr("R5 latch cleared", 8'hFB);

        cur_req = "R6";
        write_cr(8'h00);
        read_cr("R4 both cleared", 8'hF9);
        write_cr(8'h06);
        read_cr("R4 rwl needs wel", 8'hFB);
        write_cr(8'h0A);
        chk("R6 fields kept", {wpen_o, wdsel_o, bprot_o, pup_o}, 6'h3F);
        chk("R6 no busy", busy_o, 0);
        read_cr("R6 volatile only", 8'hFB);

        cur_req = "R10";
        do_addr(16'hFFFF);
        do_stop();
        chk("R10 no pulse", addr_undef_o, 0);
        tick();
        read_cr("R10 unchanged", 8'hFB);

        cur_req = "R5";
        write_cr(8'h06);
        write_cr(8'h10);
        chk("R5 second commit busy", busy_o, 1);
        repeat (CYC + 1) tick();
        read_cr("R5 second commit", 8'h12);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule